// File: doc/BRIEF.md
# Transmit Checksum Inserter

This block sits in a transmit path just ahead of the MAC. Each frame is preceded by a five-word sideband header. The header can ask for a 16-bit ones-complement checksum. The sum runs over the frame from a chosen byte offset to its last byte, starts from a seed, and is folded and inverted. The result is then written into the frame at a second chosen offset.

The insertion point may lie inside or before the summed region. For that reason the whole frame is first collected in an internal buffer. The two result bytes are patched into the buffer, and only then is the frame streamed out. Frames that transmission is not allowed to send are read in and thrown away. This covers frames that arrive while transmit is disabled, and frames of a near-jumbo size when neither jumbo nor VLAN sizes are allowed.

Every frame that is sent produces a one-cycle completion pulse and adds its length to a 64-bit byte total.

Top module: `tx_csum_inserter`

## Requirements
- R1: A header is accepted only when it has exactly 5 words, the fifth carrying `hdr_last`. If `hdr_last` arrives on any other word count, `hdr_err` pulses for one cycle in the following cycle, the header is discarded and the block keeps waiting for a header (`s_ready` stays 0).
- R2: Bit 0 of header word 0 enables the checksum. When it is 0, the frame leaves byte for byte as it arrived.
- R3: Header word 1 bits 31:16 give the start offset and bits 15:0 give the insert offset. The sum covers bytes from the start offset to the frame end, taken as big-endian 16-bit words. An odd final byte is padded with a zero low byte. A start offset at or past the frame end sums nothing.
- R4: The low 16 bits of header word 2 are added to the 32-bit sum. The total is folded twice into 16 bits and bitwise inverted.
- R5: The high result byte is written at the insert offset and the low byte at insert offset + 1. The sum is taken over the bytes as they arrived. A result byte whose position is at or past the frame end is not written.
- R6: If `cfg_tx_enable` is 0 when the last byte arrives, the frame is discarded. There is no output, no `tx_done`, and `tx_bytes` does not change.
- R7: If `cfg_jumbo_ok` and `cfg_vlan_ok` are both 0, frames of 1519 to 1522 bytes are discarded like R6. A frame of 1518 or 1523 bytes, or a frame sent with either bit set, is sent.
- R8: No output byte appears before the last input byte has been accepted. Input is not accepted while a frame is being sent. Under backpressure, `m_data` and `m_last` hold. `m_last` marks the final byte.
- R9: `tx_done` pulses for one cycle in the cycle after the last output byte is accepted. In that same cycle, `tx_bytes` grows by the frame length.
- R10: Bytes beyond `BUF_BYTES` (default 4096) are dropped. Such a frame is sent and counted as `BUF_BYTES` long.
- R11: After reset, `hdr_ready` is 1, `s_ready`, `m_valid`, `tx_done` and `hdr_err` are 0, and `tx_bytes` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_tx_enable | input | 1 | Transmit allowed |
| cfg_jumbo_ok | input | 1 | Oversize frames allowed |
| cfg_vlan_ok | input | 1 | Tagged-size frames allowed |
| hdr_valid | input | 1 | Header word valid |
| hdr_ready | output | 1 | Block can take a header word |
| hdr_word | input | 32 | Header word |
| hdr_last | input | 1 | Final header word |
| hdr_err | output | 1 | Header had the wrong length (pulse) |
| s_valid | input | 1 | Frame byte valid |
| s_ready | output | 1 | Block can take a frame byte |
| s_data | input | 8 | Frame byte |
| s_last | input | 1 | Final frame byte |
| m_valid | output | 1 | Output byte valid |
| m_ready | input | 1 | Downstream accepts the byte |
| m_data | output | 8 | Output byte |
| m_last | output | 1 | Final output byte |
| tx_done | output | 1 | Frame sent (pulse) |
| tx_bytes | output | 64 | Total bytes sent |

## Verification
The bench probes several patch placements:
- an insert offset inside the summed span, to catch a patch that corrupts the sum;
- an insert offset before the start;
- an insert offset on the final byte, where a design without the range guard would write past the frame;
- a single-byte frame.

Odd-length spans and start offsets beyond the end expose wrong byte pairing or padding, which would give a checksum off by a byte swap or by a stray byte.

The size filter is tested at both edges of the 1519–1522 window and with each override bit set. An off-by-one would send or drop the wrong frame, and the byte total would show it.

Short and long headers, a 4100-byte frame and irregular backpressure test header counting, truncation and output stability under backpressure.

// File: rtl/tx_csum_inserter.sv
module tx_csum_inserter #(
  parameter int BUF_BYTES = 4096,
  parameter int SIZE_LO   = 1519,
  parameter int SIZE_HI   = 1522
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_tx_enable,
  input  logic        cfg_jumbo_ok,
  input  logic        cfg_vlan_ok,
  input  logic        hdr_valid,
  output logic        hdr_ready,
  input  logic [31:0] hdr_word,
  input  logic        hdr_last,
  output logic        hdr_err,
  input  logic        s_valid,
  output logic        s_ready,
  input  logic [7:0]  s_data,
  input  logic        s_last,
  output logic        m_valid,
  input  logic        m_ready,
  output logic [7:0]  m_data,
  output logic        m_last,
  output logic        tx_done,
  output logic [63:0] tx_bytes
);
  localparam int AW = $clog2(BUF_BYTES);
  localparam int LW = AW + 1;
  localparam logic [2:0] HDR_END = 3'd4;

  typedef enum logic [2:0] {ST_HDR, ST_RECV, ST_PHI, ST_PLO, ST_SEND} st_t;

  st_t           st;
  logic [2:0]    hcnt;
  logic          ck_en;
  logic [15:0]   ck_start, ck_ins, ck_seed;
  logic [LW-1:0] len;
  logic [AW-1:0] rd;
  logic [31:0]   acc;
  logic [7:0]    mem [BUF_BYTES];

  assign hdr_ready = (st == ST_HDR);
  assign s_ready   = (st == ST_RECV);
  assign m_valid   = (st == ST_SEND);

  wire hdr_go = hdr_valid && hdr_ready;
  wire in_go  = s_valid && s_ready;
  wire out_go = m_valid && m_ready;

  wire           room    = len < LW'(BUF_BYTES);
  wire [LW-1:0]  len_fin = len + LW'(room);
  wire           in_sum  = 32'(len) >= 32'(ck_start);
  wire           odd     = len[0] ^ ck_start[0];
  wire [31:0]    acc_nxt = acc + (odd ? {24'd0, s_data} : {16'd0, s_data, 8'd0});
  wire           size_bad = !cfg_jumbo_ok && !cfg_vlan_ok &&
                            32'(len_fin) >= 32'(SIZE_LO) && 32'(len_fin) <= 32'(SIZE_HI);
  wire           keep    = cfg_tx_enable && !size_bad;

  wire [31:0] s1     = acc + {16'd0, ck_seed};
  wire [16:0] f1     = {1'b0, s1[15:0]} + {1'b0, s1[31:16]};
  wire [15:0] f2     = f1[15:0] + {15'd0, f1[16]};
  wire [15:0] ck_val = ~f2;
  wire [16:0] ins_lo = {1'b0, ck_ins} + 17'd1;
  wire        hi_fits = 32'(ck_ins) < 32'(len);
  wire        lo_fits = 32'(ins_lo) < 32'(len);

  logic          we;
  logic [AW-1:0] wa;
  logic [7:0]    wd;

  always_comb begin
    we = 1'b0;
    wa = '0;
    wd = '0;
    case (st)
      ST_RECV: if (in_go && room) begin
        we = 1'b1; wa = len[AW-1:0]; wd = s_data;
      end
      ST_PHI: if (ck_en && hi_fits) begin
        we = 1'b1; wa = ck_ins[AW-1:0]; wd = ck_val[15:8];
      end
      ST_PLO: if (ck_en && lo_fits) begin
        we = 1'b1; wa = ins_lo[AW-1:0]; wd = ck_val[7:0];
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) if (we) mem[wa] <= wd;

  assign m_data = mem[rd];
  assign m_last = ({1'b0, rd} == len - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_HDR;
      hcnt     <= '0;
      ck_en    <= 1'b0;
      ck_start <= '0;
      ck_ins   <= '0;
      ck_seed  <= '0;
      len      <= '0;
      rd       <= '0;
      acc      <= '0;
      hdr_err  <= 1'b0;
      tx_done  <= 1'b0;
      tx_bytes <= '0;
    end else begin
      hdr_err <= 1'b0;
      tx_done <= 1'b0;
      case (st)
        ST_HDR: if (hdr_go) begin
          case (hcnt)
            3'd0: ck_en <= hdr_word[0];
            3'd1: begin ck_start <= hdr_word[31:16]; ck_ins <= hdr_word[15:0]; end
            3'd2: ck_seed <= hdr_word[15:0];
            default: ;
          endcase
          if (hdr_last) begin
            hcnt <= '0;
            if (hcnt == HDR_END) begin
              st  <= ST_RECV;
              len <= '0;
              acc <= '0;
            end else begin
              hdr_err <= 1'b1;
            end
          end else if (hcnt != 3'd7) begin
            hcnt <= hcnt + 3'd1;
          end
        end
        ST_RECV: if (in_go) begin
          if (room) begin
            len <= len + 1'b1;
            if (in_sum) acc <= acc_nxt;
          end
          if (s_last) st <= keep ? ST_PHI : ST_HDR;
        end
        ST_PHI: st <= ST_PLO;
        ST_PLO: begin
          rd <= '0;
          st <= ST_SEND;
        end
        ST_SEND: if (out_go) begin
          rd <= rd + 1'b1;
          if (m_last) begin
            st       <= ST_HDR;
            tx_done  <= 1'b1;
            tx_bytes <= tx_bytes + 64'(len);
          end
        end
        default: st <= ST_HDR;
      endcase
    end
  end

  p_err_after_hdr_end_r1: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_err |-> $past(hdr_valid && hdr_ready && hdr_last));

  p_drop_disabled_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready && s_last && !cfg_tx_enable) |=> (hdr_ready && !m_valid));

  p_release_after_patch_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(m_valid) |-> $past(s_valid && s_ready && s_last, 3));

  p_hold_under_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data) && $stable(m_last)));

  p_done_follows_last_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |-> $past(m_valid && m_ready && m_last));

  p_count_moves_with_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_bytes != $past(tx_bytes)) |-> tx_done);
endmodule

// File: tb/tx_csum_inserter_tb.sv
`timescale 1ns/1ps
module tx_csum_inserter_tb;
  localparam int CAP = 4096;
  localparam int NV  = 8;
  localparam int V_LEN  [NV] = '{60, 61, 64, 40, 30, 20, 1518, 1};
  localparam int V_EN   [NV] = '{1, 1, 0, 1, 1, 1, 1, 1};
  localparam int V_ST   [NV] = '{14, 14, 0, 20, 29, 40, 14, 0};
  localparam int V_INS  [NV] = '{30, 16, 2, 4, 29, 2, 1516, 0};
  localparam int V_SEED [NV] = '{0, 'h1234, 'hffff, 'hffff, 0, 'habcd, 1, 0};
  localparam int V_BP   [NV] = '{0, 1, 0, 1, 0, 1, 1, 0};

  logic clk = 0, rst_n = 0;
  logic cfg_tx_enable = 1, cfg_jumbo_ok = 0, cfg_vlan_ok = 0;
  logic hdr_valid = 0, hdr_last = 0, s_valid = 0, s_last = 0, m_ready = 0;
  logic [31:0] hdr_word = 0;
  logic [7:0]  s_data = 0;
  logic hdr_ready, hdr_err, s_ready, m_valid, m_last, tx_done;
  logic [7:0]  m_data;
  logic [63:0] tx_bytes;

  int total = 0, bad = 0;
  longint unsigned exp_bytes = 0;
  logic [7:0] frm [4200];
  logic [7:0] expf [4200];
  logic [7:0] got [4200];

  always #2.5 clk = ~clk;

  tx_csum_inserter u_dut (.*);

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  function automatic logic [15:0] ref_csum(int n, int st, logic [15:0] sd);
    logic [31:0] a = 0;
    logic [16:0] b;
    logic [15:0] c;
    for (int i = st; i < n; i += 2)
      a += 32'({frm[i], ((i + 1 < n) ? frm[i+1] : 8'h00)});
    a += 32'(sd);
    b = {1'b0, a[15:0]} + {1'b0, a[31:16]};
    c = b[15:0] + {15'd0, b[16]};
    return ~c;
  endfunction

  task automatic send_hdr(input logic [31:0] w0, w1, w2, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      hdr_valid = 1;
      hdr_word = (i == 0) ? w0 : (i == 1) ? w1 : (i == 2) ? w2 : 32'h0;
      hdr_last = (i == n - 1);
      while (!hdr_ready) @(negedge clk);
      @(posedge clk);
    end
    @(negedge clk);
    hdr_valid = 0;
    hdr_last = 0;
  endtask

  task automatic send_frm(input int n, output bit early);
    early = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      s_valid = 1;
      s_data = frm[i];
      s_last = (i == n - 1);
      if (m_valid) early = 1;
      while (!s_ready) @(negedge clk);
      @(posedge clk);
    end
    @(negedge clk);
    s_valid = 0;
    s_last = 0;
  endtask

  task automatic fill(input int k, input int n);
    for (int i = 0; i < n; i++) frm[i] = 8'((i * 37) + (k * 11) + 5);
  endtask

  task automatic run_frame(input int k, input int en, input int st, input int ins,
                           input int sd, input int n, input bit bp, input string req);
    int stored, cnt, mism, guard, cyc;
    bit early, overlap, fin;
    logic [15:0] c;
    fill(k, n);
    stored = (n > CAP) ? CAP : n;
    for (int i = 0; i < stored; i++) expf[i] = frm[i];
    c = ref_csum(stored, st, 16'(sd));
    if (en != 0) begin
      if (ins < stored) expf[ins] = c[15:8];
      if (ins + 1 < stored) expf[ins+1] = c[7:0];
    end
    send_hdr({31'd0, 1'(en)}, {16'(st), 16'(ins)}, {16'd0, 16'(sd)}, 5);
    chk(!hdr_err && s_ready, "R1", "good header not taken", {hdr_err, s_ready}, 2'b01);
    send_frm(n, early);
    chk(!early, "R8", "output before last input", early, 0);
    cnt = 0; mism = 0; guard = 0; cyc = 0; fin = 0; overlap = 0;
    while (!fin && guard < 20000) begin
      @(negedge clk);
      m_ready = bp ? ((cyc % 3) != 2) : 1'b1;
      cyc++;
      if (m_valid && s_ready) overlap = 1;
      if (m_valid && m_ready) begin
        if (cnt < 4200) got[cnt] = m_data;
        cnt++;
        fin = m_last;
      end
      @(posedge clk);
      guard++;
    end
    @(negedge clk);
    m_ready = 0;
    exp_bytes += longint'(stored);
    chk(tx_done == 1'b1, "R9", {req, " tx_done"}, tx_done, 1);
    chk(tx_bytes == exp_bytes, "R9", {req, " byte total"}, tx_bytes, exp_bytes);
    chk(cnt == stored, req, "frame length", cnt, stored);
    chk(!overlap, "R8", "input open during output", overlap, 0);
    for (int i = 0; i < stored && i < cnt; i++) if (got[i] !== expf[i]) mism++;
    chk(mism == 0, req, "byte mismatches", mism, 0);
    @(negedge clk);
    chk(tx_done == 1'b0, "R9", "tx_done width", tx_done, 0);
  endtask

  task automatic run_drop(input int n, input string req);
    bit early, seen;
    fill(9, n);
    send_hdr(32'h1, {16'd0, 16'd2}, 32'h0, 5);
    send_frm(n, early);
    seen = 0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (m_valid || tx_done) seen = 1;
    end
    chk(!seen && hdr_ready, req, "dropped frame produced output", {seen, hdr_ready}, 2'b01);
    chk(tx_bytes == exp_bytes, req, "byte total after drop", tx_bytes, exp_bytes);
  endtask

  initial begin
    #1000000;
    bad++;
    total++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    // R11 reset state
    chk(hdr_ready && !s_ready && !m_valid && !tx_done && !hdr_err && tx_bytes == 0,
        "R11", "reset outputs", {hdr_ready, s_ready, m_valid, tx_done, hdr_err}, 5'b10000);
    rst_n = 1;
    @(negedge clk);

    for (int k = 0; k < NV; k++)
      run_frame(k, V_EN[k], V_ST[k], V_INS[k], V_SEED[k], V_LEN[k], V_BP[k] != 0,
                (V_EN[k] == 0) ? "R2" : (k == 4) ? "R5" : (k == 5) ? "R3" : "R4");

    // R1 short and long headers
    send_hdr(32'h1, 32'h0, 32'h0, 4);
    chk(hdr_err == 1'b1, "R1", "short header error", hdr_err, 1);
    chk(!s_ready && hdr_ready, "R1", "short header state", {s_ready, hdr_ready}, 2'b01);
    send_hdr(32'h1, 32'h0, 32'h0, 6);
    chk(hdr_err == 1'b1, "R1", "long header error", hdr_err, 1);
    chk(!s_ready && hdr_ready, "R1", "long header state", {s_ready, hdr_ready}, 2'b01);
    run_frame(20, 1, 0, 6, 'h55, 25, 1'b0, "R3");

    // R6 transmit disabled
    cfg_tx_enable = 0;
    run_drop(60, "R6");
    cfg_tx_enable = 1;

    // R7 size window edges and overrides
    run_drop(1519, "R7");
    run_drop(1522, "R7");
    run_frame(21, 1, 14, 20, 0, 1523, 1'b0, "R7");
    cfg_vlan_ok = 1;
    run_frame(22, 1, 14, 20, 0, 1520, 1'b0, "R7");
    cfg_vlan_ok = 0;
    cfg_jumbo_ok = 1;
    run_frame(23, 0, 0, 0, 0, 1521, 1'b1, "R7");
    cfg_jumbo_ok = 0;

    // R10 oversize frame truncated
    run_frame(24, 1, 4000, 4094, 'h0f0f, 4100, 1'b0, "R10");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule